// File: doc/BRIEF.md
# OTG Event Interrupt Status Unit

This unit gathers the general events of a USB On-The-Go controller into eight sticky status flags. The flags are suspend time-out, negotiation error, role exchange, B-side connection error, supply error, session request seen, supply pad transition and ID pad transition. The surrounding controller sends most events as one-cycle pulses. The unit qualifies some of them by the current host/device role. It also counts a suspend watchdog itself and watches the supply and ID pads for edges in either direction. Each flag has an enable bit and a write-one-to-clear bit. One interrupt line goes high while any enabled flag is set.

The pad watchers run on a free-running low-speed clock, so pad edges are still caught while the main clock is frozen (the `freeze` input). During a freeze, the main-domain flags and the watchdog hold their values. A pad-flag clear crosses into the low-speed domain through a toggle handshake. The status bit of that pad flag reads zero while the clear is in flight.

Top module: `otg_evt_irq`

## Requirements
- R1: After reset, `status` is 8'h00 and `irq` is 0.
- R2: A qualified event pulse sets its flag at the clock edge that samples it. The flag stays set until that bit of `clr_w1c` is written with one. Bit map: 0 suspend time-out, 1 negotiation error, 2 role exchange, 3 B-connection error, 4 supply error, 5 session request, 6 supply pad transition, 7 ID pad transition.
- R3: A `clr_w1c` write clears only the bits written with one. When a set event and a clear of the same bit arrive in the same cycle, the flag stays set.
- R4: `irq` is 1 exactly when some bit of `status & irq_en` is 1.
- R5: Bits 0, 3, 4 and 5 set only when `host_mode` is 1. Bit 1 sets only when `host_mode` is 0. Bit 2 sets in either mode.
- R6: Both a rising and a falling level change on `vbus_pad` set bit 6.
- R7: Both a rising and a falling level change on `id_pad` set bit 7.
- R8: While `freeze` is 1, pad edges still set bits 6 and 7 and raise `irq` when enabled. Bits 0 to 5, the watchdog and all clears hold.
- R9: With `host_mode` 1 and `suspend` held at 1, bit 0 sets on the clock edge numbered (TIMEOUT_MS+1)*TICK_CYCLES, counting from the first edge that samples `suspend` high. It sets once per suspend. Dropping `suspend` restarts the count.
- R10: After a clear of bit 6 or 7, that status bit reads 0 until a new pad edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Main asynchronous reset, active low |
| ls_clk | input | 1 | Free-running low-speed clock for pad watching |
| ls_rst_n | input | 1 | Low-speed domain reset, active low |
| freeze | input | 1 | Main clock frozen: main-domain state holds |
| host_mode | input | 1 | 1 = host role, 0 = device role |
| suspend | input | 1 | Bus suspended; runs the watchdog |
| ev_hnp_err | input | 1 | Negotiation error pulse |
| ev_role_ex | input | 1 | Role switch done pulse |
| ev_bconn_err | input | 1 | B-connection error pulse |
| ev_vbus_drop | input | 1 | Supply drop pulse |
| ev_srp | input | 1 | Session request seen pulse |
| vbus_pad | input | 1 | Supply pad level, asynchronous |
| id_pad | input | 1 | ID pad level, asynchronous |
| irq_en | input | 8 | Per-flag interrupt enables |
| clr_w1c | input | 8 | Write-one-to-clear strobes, one cycle |
| status | output | 8 | Sticky flags |
| irq | output | 1 | Combined interrupt |

## Verification
A flag that fails to hold or fails to clear shows on `status` by the next main clock edge, and on `irq` at once when that bit is enabled. A wrong edge detector or a broken handshake in the pad path shows only after the synchronizer latency, a few low-speed cycles. The bench therefore lets each pad step settle before it compares. A watchdog count that is off by even one edge moves the set of bit 0 by one cycle. The bench probes the cycle just before and the cycle of the expected set.

// File: rtl/otg_evt_pkg.sv
package otg_evt_pkg;
   localparam int NFLAG = 8;
   localparam int NCORE = 6;
   localparam int NPIN  = NFLAG - NCORE;
   localparam int B_SUSP = 0;
   localparam int B_HNP  = 1;
   localparam int B_ROLE = 2;
   localparam int B_BCON = 3;
   localparam int B_VERR = 4;
   localparam int B_SRP  = 5;
endpackage

// File: rtl/otg_evt_flagbank.sv
module otg_evt_flagbank #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag <= '0;
      else if (!hold) flag <= (flag & ~clr) | set;
   end

   // R2: an uncleared flag stays set
   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !hold |=> ((flag & $past(flag & ~clr)) == $past(flag & ~clr)));
   // R3: set wins over a clear in the same cycle
   p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && (set != '0)) |=> ((flag & $past(set)) == $past(set)));
   // R3: cleared bits without a set go low
   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !hold |=> ((flag & $past(clr & ~set)) == '0));
   // R8: frozen flags hold
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(flag));
endmodule

// File: rtl/otg_evt_susp_timer.sv
module otg_evt_susp_timer #(
   parameter int TICK_CYCLES = 50000,
   parameter int TIMEOUT_MS  = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic active,
   output logic expired
);
   localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
   localparam int MW = $clog2(TIMEOUT_MS + 2);

   logic [PW-1:0] pre;
   logic [MW-1:0] ms;
   logic          tick;

   assign tick    = (pre == PW'(TICK_CYCLES - 1));
   assign expired = active & ~hold & tick & (ms == MW'(TIMEOUT_MS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre <= '0;
         ms  <= '0;
      end else if (!active) begin
         pre <= '0;
         ms  <= '0;
      end else if (!hold) begin
         pre <= tick ? '0 : pre + PW'(1);
         if (tick && (ms != MW'(TIMEOUT_MS + 1))) ms <= ms + MW'(1);
      end
   end

   // R9: one expiry per suspend
   p_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
      expired |=> !expired);
   // R9: leaving suspend restarts the count
   p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (ms == '0 && pre == '0));
endmodule

// File: rtl/otg_evt_pinwatch.sv
module otg_evt_pinwatch (
   input  logic clk,
   input  logic rst_n,
   input  logic ls_clk,
   input  logic ls_rst_n,
   input  logic pad,
   input  logic clr,
   output logic stat,
   output logic irq_src
);
   // low-speed domain
   logic [1:0] pad_s;
   logic       pad_q;
   logic [1:0] warm;
   logic [1:0] req_s;
   logic       ack;
   logic       flag;
   logic       edge_hit;
   logic       clr_hit;
   // main domain
   logic       req;
   logic       again;
   logic [1:0] ack_s;
   logic [1:0] flag_s;
   logic       pend_d;
   logic       pending;

   assign edge_hit = (warm == 2'd3) & (pad_s[1] ^ pad_q);
   assign clr_hit  = req_s[1] ^ ack;

   always_ff @(posedge ls_clk or negedge ls_rst_n) begin
      if (!ls_rst_n) begin
         pad_s <= '0;
         pad_q <= 1'b0;
         warm  <= '0;
         req_s <= '0;
         ack   <= 1'b0;
         flag  <= 1'b0;
      end else begin
         pad_s <= {pad_s[0], pad};
         pad_q <= pad_s[1];
         if (warm != 2'd3) warm <= warm + 2'd1;
         req_s <= {req_s[0], req};
         ack   <= req_s[1];
         if (edge_hit)     flag <= 1'b1;
         else if (clr_hit) flag <= 1'b0;
      end
   end

   assign pending = req ^ ack_s[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req    <= 1'b0;
         again  <= 1'b0;
         ack_s  <= '0;
         flag_s <= '0;
         pend_d <= 1'b0;
      end else begin
         ack_s  <= {ack_s[0], ack};
         flag_s <= {flag_s[0], flag};
         pend_d <= pending;
         if (!pending && (clr || again)) begin
            req   <= ~req;
            again <= 1'b0;
         end else if (clr) begin
            again <= 1'b1;
         end
      end
   end

   assign stat    = flag_s[1] & ~pending & ~pend_d;
   assign irq_src = flag & ~pending;

   // R6/R7: a detected pad edge always lands in the flag
   p_edge_sets_r6: assert property (@(posedge ls_clk) disable iff (!ls_rst_n)
      edge_hit |=> flag);
   // R10: a clear masks the status bit on the next cycle
   p_clear_masks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !pending) |=> !stat);
endmodule

// File: rtl/otg_evt_irq.sv
module otg_evt_irq
   import otg_evt_pkg::*;
#(
   parameter int TICK_CYCLES = 50000,
   parameter int TIMEOUT_MS  = 200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ls_clk,
   input  logic             ls_rst_n,
   input  logic             freeze,
   input  logic             host_mode,
   input  logic             suspend,
   input  logic             ev_hnp_err,
   input  logic             ev_role_ex,
   input  logic             ev_bconn_err,
   input  logic             ev_vbus_drop,
   input  logic             ev_srp,
   input  logic             vbus_pad,
   input  logic             id_pad,
   input  logic [NFLAG-1:0] irq_en,
   input  logic [NFLAG-1:0] clr_w1c,
   output logic [NFLAG-1:0] status,
   output logic             irq
);
   if (TICK_CYCLES < 1) begin : g_bad_tick
      $error("TICK_CYCLES must be at least 1");
   end
   if (TIMEOUT_MS < 1) begin : g_bad_tmo
      $error("TIMEOUT_MS must be at least 1");
   end

   logic [NCORE-1:0] core_set;
   logic [NCORE-1:0] core_flag;
   logic [NPIN-1:0]  pads;
   logic [NPIN-1:0]  pin_stat;
   logic [NPIN-1:0]  pin_irq;
   logic             tmo;

   otg_evt_susp_timer #(.TICK_CYCLES(TICK_CYCLES), .TIMEOUT_MS(TIMEOUT_MS)) u_timer (
      .clk(clk), .rst_n(rst_n), .hold(freeze),
      .active(suspend & host_mode), .expired(tmo));

   always_comb begin
      core_set         = '0;
      core_set[B_SUSP] = tmo;
      core_set[B_HNP]  = ev_hnp_err & ~host_mode;
      core_set[B_ROLE] = ev_role_ex;
      core_set[B_BCON] = ev_bconn_err & host_mode;
      core_set[B_VERR] = ev_vbus_drop & host_mode;
      core_set[B_SRP]  = ev_srp & host_mode;
   end

   otg_evt_flagbank #(.N(NCORE)) u_flags (
      .clk(clk), .rst_n(rst_n), .hold(freeze),
      .set(core_set), .clr(clr_w1c[NCORE-1:0]), .flag(core_flag));

   assign pads = {id_pad, vbus_pad};

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      otg_evt_pinwatch u_watch (
         .clk(clk), .rst_n(rst_n), .ls_clk(ls_clk), .ls_rst_n(ls_rst_n),
         .pad(pads[i]), .clr(clr_w1c[NCORE+i] & ~freeze),
         .stat(pin_stat[i]), .irq_src(pin_irq[i]));
   end

   assign status = {pin_stat, core_flag};
   assign irq    = (|(core_flag & irq_en[NCORE-1:0])) | (|(pin_irq & irq_en[NFLAG-1:NCORE]));

   // R4: an enabled core flag drives the line
   p_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((status[NCORE-1:0] & irq_en[NCORE-1:0]) != '0) |-> irq);
   // R5: negotiation error only in device role
   p_hnp_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[B_HNP]) |-> $past(!host_mode));
   // R5: session request only in host role
   p_srp_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[B_SRP]) |-> $past(host_mode));
endmodule

// File: tb/otg_evt_irq_bench.sv
module otg_evt_irq_bench;
   logic       clk = 1'b0, ls_clk = 1'b0;
   logic       rst_n = 1'b0, ls_rst_n = 1'b0;
   logic       freeze = 1'b0, host_mode = 1'b0, suspend = 1'b0;
   logic       ev_hnp_err = 1'b0, ev_role_ex = 1'b0, ev_bconn_err = 1'b0;
   logic       ev_vbus_drop = 1'b0, ev_srp = 1'b0;
   logic       vbus_pad = 1'b0, id_pad = 1'b0;
   logic [7:0] irq_en = 8'h00, clr_w1c = 8'h00;
   logic [7:0] status;
   logic       irq;

   always #10 clk = ~clk;
   always #50 ls_clk = ~ls_clk;

   otg_evt_irq #(.TICK_CYCLES(4), .TIMEOUT_MS(5)) u_otg_evt_irq (
      .clk(clk), .rst_n(rst_n), .ls_clk(ls_clk), .ls_rst_n(ls_rst_n),
      .freeze(freeze), .host_mode(host_mode), .suspend(suspend),
      .ev_hnp_err(ev_hnp_err), .ev_role_ex(ev_role_ex), .ev_bconn_err(ev_bconn_err),
      .ev_vbus_drop(ev_vbus_drop), .ev_srp(ev_srp), .vbus_pad(vbus_pad), .id_pad(id_pad),
      .irq_en(irq_en), .clr_w1c(clr_w1c), .status(status), .irq(irq));

   typedef struct {
      string      tag;
      logic [7:0] st;
      logic       ir;
   } exp_t;

   exp_t q[$];
   exp_t cur;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   // monitor: compares every queued expectation away from the active edge
   always @(negedge clk) begin
      while (q.size() > 0) begin
         cur = q.pop_front();
         checks++;
         if (status !== cur.st || irq !== cur.ir) begin
            errors++;
            $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                     cur.tag, status, irq, cur.st, cur.ir);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic expect_st(input string tag, input logic [7:0] st, input logic ir);
      exp_t e;
      e.tag = tag;
      e.st  = st;
      e.ir  = ir;
      q.push_back(e);
      step(1);
   endtask

   task automatic wclr(input logic [7:0] m);
      clr_w1c = m;
      step(1);
      clr_w1c = 8'h00;
   endtask

   task automatic pulse(input int which);
      case (which)
         0: ev_hnp_err   = 1'b1;
         1: ev_role_ex   = 1'b1;
         2: ev_bconn_err = 1'b1;
         3: ev_vbus_drop = 1'b1;
         default: ev_srp = 1'b1;
      endcase
      step(1);
      ev_hnp_err = 1'b0; ev_role_ex = 1'b0; ev_bconn_err = 1'b0;
      ev_vbus_drop = 1'b0; ev_srp = 1'b0;
   endtask

   initial begin
      step(5);
      rst_n = 1'b1; ls_rst_n = 1'b1;
      step(10);
      expect_st("R1 reset state", 8'h00, 1'b0);

      pulse(0);
      expect_st("R2 hnp error set in device mode", 8'h02, 1'b0);
      irq_en = 8'h02; #1;
      expect_st("R4 irq follows enable", 8'h02, 1'b1);
      step(3);
      expect_st("R2 flag sticky", 8'h02, 1'b1);
      wclr(8'h01);
      expect_st("R3 other bit cleared only", 8'h02, 1'b1);
      wclr(8'h02);
      expect_st("R3 bit cleared", 8'h00, 1'b0);

      host_mode = 1'b1;
      pulse(0);
      expect_st("R5 hnp error ignored in host", 8'h00, 1'b0);
      pulse(4);
      expect_st("R5 srp in host", 8'h20, 1'b0);
      pulse(2);
      expect_st("R5 bconn in host", 8'h28, 1'b0);
      pulse(3);
      expect_st("R5 vbus error in host", 8'h38, 1'b0);
      pulse(1);
      expect_st("R2 role exchange in host", 8'h3C, 1'b0);
      irq_en = 8'hFF; #1;
      expect_st("R4 irq all enabled", 8'h3C, 1'b1);

      host_mode = 1'b0;
      wclr(8'h3C);
      expect_st("R3 multi clear", 8'h00, 1'b0);
      pulse(4); pulse(2); pulse(3);
      expect_st("R5 host-only events ignored in device", 8'h00, 1'b0);
      pulse(1);
      expect_st("R5 role exchange in device", 8'h04, 1'b1);
      clr_w1c = 8'h04; ev_role_ex = 1'b1;
      step(1);
      clr_w1c = 8'h00; ev_role_ex = 1'b0;
      expect_st("R3 set beats clear", 8'h04, 1'b1);
      wclr(8'h04);
      expect_st("R3 clear after tie", 8'h00, 1'b0);

      vbus_pad = 1'b1; step(40);
      expect_st("R6 vbus rising edge", 8'h40, 1'b1);
      wclr(8'h40); step(40);
      expect_st("R10 pad flag cleared", 8'h00, 1'b0);
      vbus_pad = 1'b0; step(40);
      expect_st("R6 vbus falling edge", 8'h40, 1'b1);
      wclr(8'h40); step(40);
      id_pad = 1'b1; step(40);
      expect_st("R7 id rising edge", 8'h80, 1'b1);
      wclr(8'h80); step(40);
      id_pad = 1'b0; step(40);
      expect_st("R7 id falling edge", 8'h80, 1'b1);
      wclr(8'h80); step(40);
      expect_st("R10 id flag cleared", 8'h00, 1'b0);

      freeze = 1'b1; step(1);
      pulse(1);
      expect_st("R8 core flag held while frozen", 8'h00, 1'b0);
      vbus_pad = 1'b1; step(40);
      expect_st("R8 vbus edge caught while frozen", 8'h40, 1'b1);
      wclr(8'h40); step(40);
      expect_st("R8 clear held while frozen", 8'h40, 1'b1);
      freeze = 1'b0; step(1);
      wclr(8'h40); step(40);
      expect_st("R10 clear after unfreeze", 8'h00, 1'b0);

      host_mode = 1'b1; irq_en = 8'h01; step(1);
      suspend = 1'b1;
      step(23);
      expect_st("R9 watchdog not yet expired", 8'h00, 1'b0);
      expect_st("R9 watchdog expires on edge 24", 8'h01, 1'b1);
      wclr(8'h01);
      suspend = 1'b0; step(2);
      expect_st("R9 fires once per suspend", 8'h00, 1'b0);
      suspend = 1'b1; step(20);
      suspend = 1'b0; step(1);
      suspend = 1'b1;
      step(23);
      expect_st("R9 count restarted by suspend drop", 8'h00, 1'b0);
      expect_st("R9 expires after restart", 8'h01, 1'b1);
      suspend = 1'b0;
      step(3);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run hung, actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule